// File: doc/BRIEF.md
# Reference Loss Supervisor with Status Select

This block watches the reference input of a phase-locked loop from the VCO clock domain. The monitor stays disarmed until the loop's digital lock-detect input has been true for a programmable number of PFD-rate strobes. It then checks that rising edges of the reference, synchronised into the VCO domain, keep arriving. If the reference stops, a sticky loss flag is set and the charge-pump tri-state control is forced active. Both stay set until software clears the monitor enable. Because the monitor is clocked by the VCO, it cannot report a loss while the VCO is stopped.

A single status pin is driven through a 4-bit select code. The code can present the loss flag on its own, or the OR of loss-of-lock and loss-of-reference, each in an active-high or an active-low form. Lock detect can stay true after the reference has vanished, so the combined form exists to cover that case.

Top module: `refLossMonitor`

## Requirements
- R1: After reset, lossFlag, cpTristate and statusOut are 0 and the monitor is disarmed.
- R2: With monEnable at 1, the monitor arms once lockDet has been 1 on (3 << armDelaySel) pfdTick strobes. The arming delay field maps 00 to 3, 01 to 6, 10 to 12 and 11 to 24 strobes.
- R3: If lockDet is 0 in any cycle before arming completes, the locked-strobe count restarts from zero.
- R4: Once armed, if no synchronised rising edge of refClk is seen for 4*refRatio VCO cycles, lossFlag and cpTristate go to 1 on the next clock. refRatio must be at least 1.
- R5: While reference edges keep arriving more often than the limit in R4, lossFlag stays 0, whatever the state of lockDet.
- R6: The loss condition is sticky while monEnable is 1. Setting monEnable to 0 clears lossFlag and cpTristate on the next clock. Setting it back to 1 starts the arming count again from zero.
- R7: Select code 1010 drives statusOut with lossFlag. Code 1111 drives the inverse of lossFlag.
- R8: Select code 1101 drives statusOut with (not lockDet) OR lossFlag. Code 1110 drives the inverse of that signal.
- R9: Every other select code drives statusOut to 0.
- R10: A missing reference before arming, or while monEnable is 0, sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-domain clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pfdTick | input | 1 | One-cycle strobe at the PFD rate |
| lockDet | input | 1 | Digital lock-detect indication |
| refClk | input | 1 | Reference clock (asynchronous) |
| monEnable | input | 1 | Monitor enable |
| armDelaySel | input | 2 | Arming delay code |
| refRatio | input | 8 | VCO cycles per PFD period |
| muxSel | input | 4 | Status select code |
| lossFlag | output | 1 | Sticky loss-of-reference flag |
| cpTristate | output | 1 | Charge-pump tri-state control |
| statusOut | output | 1 | Selected status signal |

## Verification
The reference is tried in three patterns: running steadily, stopped before lock, and stopped after lock. These separate a correct loss detection from false alarms and from reports made before arming. Lock detect is dropped partway through an arming count with the reference already stopped. A design that kept the partial count would raise the flag early, while a correct one would not. The sticky state is held, cleared through the enable and re-armed, and every select code is swept under different combinations of flag and lock. This shows the polarity of each code and that the unused codes stay low.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

  typedef struct packed {
    logic armRun;
    logic toRun;
  } monStrobe_t;

  typedef enum logic [1:0] {
    MON_OFF   = 2'd0,
    MON_COUNT = 2'd1,
    MON_ARMED = 2'd2,
    MON_LOST  = 2'd3
  } monState_t;

  localparam logic [3:0] SEL_LOSS_HI = 4'b1010;
  localparam logic [3:0] SEL_LOSS_LO = 4'b1111;
  localparam logic [3:0] SEL_ANY_HI  = 4'b1101;
  localparam logic [3:0] SEL_ANY_LO  = 4'b1110;

endpackage

// File: rtl/refmon_datapath.sv
module refmon_datapath
  import refmon_pkg::*;
#(
  parameter int ARM_BASE    = 3,
  parameter int RATIO_W     = 8,
  parameter int PERIODS     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refClk,
  input  logic               pfdTick,
  input  logic               lockDet,
  input  logic [1:0]         armDelaySel,
  input  logic [RATIO_W-1:0] refRatio,
  input  monStrobe_t         strb,
  output logic               armDone,
  output logic               refMissing
);

  localparam int ARM_W = $clog2(ARM_BASE * 8 + 1);
  localparam int TO_W  = RATIO_W + $clog2(PERIODS) + 1;

  logic [SYNC_STAGES:0] refPipe;
  logic                 refEdge;
  logic [ARM_W-1:0]     armCnt;
  logic [ARM_W-1:0]     armTarget;
  logic [TO_W-1:0]      toCnt;
  logic [TO_W-1:0]      toLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refPipe <= '0;
    else       refPipe <= {refPipe[SYNC_STAGES-1:0], refClk};
  end

  assign refEdge = refPipe[SYNC_STAGES-1] & ~refPipe[SYNC_STAGES];

  assign armTarget = ARM_W'(ARM_BASE) << armDelaySel;
  assign armDone   = (armCnt >= armTarget);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        armCnt <= '0;
    else if (!strb.armRun || !lockDet) armCnt <= '0;
    else if (pfdTick && !armDone)      armCnt <= armCnt + 1'b1;
  end

  assign toLimit    = TO_W'(refRatio) * TO_W'(PERIODS);
  assign refMissing = (toCnt >= toLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      toCnt <= '0;
    else if (!strb.toRun || refEdge) toCnt <= '0;
    else if (!refMissing)            toCnt <= toCnt + 1'b1;
  end

  // R2: the locked-strobe count never runs past the selected target
  assert_arm_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armCnt <= armTarget) || !$stable(armDelaySel));

  // R4: a synchronised reference edge restarts the silence window
  assert_edge_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    (refEdge && strb.toRun) |=> !refMissing || (toLimit == '0));

endmodule

// File: rtl/refmon_control.sv
module refmon_control
  import refmon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       monEnable,
  input  logic       lockDet,
  input  logic [3:0] muxSel,
  input  logic       armDone,
  input  logic       refMissing,
  output monStrobe_t strb,
  output logic       lossFlag,
  output logic       cpTristate,
  output logic       statusOut
);

  monState_t state, stateNext;
  logic      armedNow;
  logic      anyFault;

  always_comb begin
    stateNext = state;
    unique case (state)
      MON_OFF:   if (monEnable) stateNext = MON_COUNT;
      MON_COUNT: if (!monEnable) stateNext = MON_OFF;
                 else if (armDone) stateNext = MON_ARMED;
      MON_ARMED: if (!monEnable) stateNext = MON_OFF;
                 else if (refMissing) stateNext = MON_LOST;
      MON_LOST:  if (!monEnable) stateNext = MON_OFF;
      default:   stateNext = MON_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MON_OFF;
    else       state <= stateNext;
  end

  assign armedNow    = (state == MON_ARMED);
  assign strb.armRun = (state == MON_COUNT);
  assign strb.toRun  = armedNow;
  assign lossFlag    = (state == MON_LOST);
  assign cpTristate  = (state == MON_LOST);
  assign anyFault    = ~lockDet | lossFlag;

  always_comb begin
    unique case (muxSel)
      SEL_LOSS_HI: statusOut = lossFlag;
      SEL_LOSS_LO: statusOut = ~lossFlag;
      SEL_ANY_HI:  statusOut = anyFault;
      SEL_ANY_LO:  statusOut = ~anyFault;
      default:     statusOut = 1'b0;
    endcase
  end

  // R2: arming happens only after the datapath reports the count complete
  assert_arm_after_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armedNow) |-> $past(armDone));

  // R4: the flag rises only on a reported silence
  assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lossFlag) |-> $past(refMissing) && $past(monEnable));

  // R6: sticky while enabled
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lossFlag && monEnable) |=> lossFlag);

  // R6: disabling clears flag and tri-state
  assert_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    !monEnable |=> !lossFlag && !cpTristate);

endmodule

// File: rtl/refLossMonitor.sv
module refLossMonitor
  import refmon_pkg::*;
#(
  parameter int ARM_BASE    = 3,
  parameter int RATIO_W     = 8,
  parameter int PERIODS     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pfdTick,
  input  logic               lockDet,
  input  logic               refClk,
  input  logic               monEnable,
  input  logic [1:0]         armDelaySel,
  input  logic [RATIO_W-1:0] refRatio,
  input  logic [3:0]         muxSel,
  output logic               lossFlag,
  output logic               cpTristate,
  output logic               statusOut
);

  monStrobe_t strb;
  logic       armDone;
  logic       refMissing;

  refmon_datapath #(
    .ARM_BASE(ARM_BASE), .RATIO_W(RATIO_W),
    .PERIODS(PERIODS), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .refClk(refClk), .pfdTick(pfdTick),
    .lockDet(lockDet), .armDelaySel(armDelaySel), .refRatio(refRatio),
    .strb(strb), .armDone(armDone), .refMissing(refMissing)
  );

  refmon_control u_ctl (
    .clk(clk), .rstN(rstN), .monEnable(monEnable), .lockDet(lockDet),
    .muxSel(muxSel), .armDone(armDone), .refMissing(refMissing),
    .strb(strb), .lossFlag(lossFlag), .cpTristate(cpTristate),
    .statusOut(statusOut)
  );

endmodule

// File: tb/refLossMonitor_test.sv
`timescale 1ns/1ps
module refLossMonitor_test;

  logic       clk = 0;
  logic       rstN = 0;
  logic       pfdTick = 0;
  logic       lockDet = 0;
  logic       refClk = 0;
  logic       monEnable = 0;
  logic [1:0] armDelaySel = 0;
  logic [7:0] refRatio = 8'd4;
  logic [3:0] muxSel = 4'b1010;
  logic       lossFlag, cpTristate, statusOut;

  int checks = 0, errors = 0, cyc = 0;
  bit refRun = 0;
  int refPh = 0, tickPh = 0;

  // behavioural model state
  int mSt = 0, mArm = 0, mTo = 0;
  bit q1 = 0, q2 = 0, q3 = 0;

  refLossMonitor uut (
    .clk(clk), .rstN(rstN), .pfdTick(pfdTick), .lockDet(lockDet),
    .refClk(refClk), .monEnable(monEnable), .armDelaySel(armDelaySel),
    .refRatio(refRatio), .muxSel(muxSel), .lossFlag(lossFlag),
    .cpTristate(cpTristate), .statusOut(statusOut)
  );

  always #5 clk = ~clk;

  function automatic bit expStatus(bit loss, bit lk, logic [3:0] s);
    case (s)
      4'b1010: return loss;
      4'b1111: return !loss;
      4'b1101: return !lk || loss;
      4'b1110: return !(!lk || loss);
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0b expected %0b", req, cyc, act, exp);
    end
  endtask

  // model advance on each edge
  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mSt = 0; mArm = 0; mTo = 0; q1 = 0; q2 = 0; q3 = 0;
    end else begin
      bit edgeSeen, miss, done;
      int tgt, nxt;
      edgeSeen = q2 && !q3;
      tgt = 3 << armDelaySel;
      miss = (mTo >= 4 * refRatio);
      done = (mArm >= tgt);
      nxt = mSt;
      if (!monEnable) nxt = 0;
      else if (mSt == 0) nxt = 1;
      else if (mSt == 1 && done) nxt = 2;
      else if (mSt == 2 && miss) nxt = 3;
      if (mSt != 1 || !lockDet) mArm = 0;
      else if (pfdTick && !done) mArm++;
      if (mSt != 2 || edgeSeen) mTo = 0;
      else if (!miss) mTo++;
      mSt = nxt;
      q3 = q2; q2 = q1; q1 = refClk;
    end
  end

  // compare away from the edge, then drive free-running stimulus
  always @(negedge clk) begin
    if (rstN) begin
      check("R4/R6 flag", lossFlag, mSt == 3);
      check("R4/R6 tristate", cpTristate, mSt == 3);
      check("R7/R8/R9 status", statusOut, expStatus(mSt == 3, lockDet, muxSel));
    end
    tickPh = (tickPh + 1) % 8;
    pfdTick = (tickPh == 0);
    if (refRun) begin
      refPh = (refPh + 1) % 4;
      if (refPh == 0) refClk = ~refClk;
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitCyc(3);
    check("R1 flag", lossFlag, 0);
    check("R1 tristate", cpTristate, 0);
    check("R1 status", statusOut, 0);
    rstN = 1;
    waitCyc(2);
    // R10: reference absent, lock low -> never arms
    monEnable = 1; lockDet = 0;
    waitCyc(200);
    check("R10 no flag before arming", lossFlag, 0);
    // R5: running reference, locked
    refRun = 1; lockDet = 1;
    waitCyc(300);
    check("R5 steady reference", lossFlag, 0);
    lockDet = 0; waitCyc(20); lockDet = 1;
    // R4: reference stops
    refRun = 0;
    waitCyc(60);
    check("R4 flag after silence", lossFlag, 1);
    check("R4 tristate after silence", cpTristate, 1);
    // R6 sticky, then release
    refRun = 1; waitCyc(50);
    check("R6 sticky", lossFlag, 1);
    monEnable = 0; waitCyc(1);
    check("R6 release flag", lossFlag, 0);
    check("R6 release tristate", cpTristate, 0);
    // R10: disabled, reference silent
    refRun = 0; waitCyc(150);
    check("R10 disabled", lossFlag, 0);
    // R3: sel 01 (6 ticks), lock drop mid-count, reference silent
    armDelaySel = 2'b01; monEnable = 1;
    waitCyc(32);
    lockDet = 0; waitCyc(2); lockDet = 1;
    waitCyc(40 + 20);
    check("R3 restart after lock drop", lossFlag, 0);
    waitCyc(16 + 40);
    check("R2 armed after six strobes", lossFlag, 1);
    // R2: longest delay
    monEnable = 0; waitCyc(2);
    armDelaySel = 2'b11; refRatio = 8'd3; monEnable = 1;
    waitCyc(150);
    check("R2 not yet armed at 24 strobes", lossFlag, 0);
    waitCyc(100);
    check("R2 armed at 24 strobes", lossFlag, 1);
    // select sweep: flag 1, lock 1 and lock 0
    for (int lk = 1; lk >= 0; lk--) begin
      lockDet = lk[0];
      for (int s = 0; s < 16; s++) begin
        muxSel = s[3:0]; waitCyc(1);
        check("R7/R8/R9 sweep loss", statusOut, expStatus(1, lk[0], s[3:0]));
      end
    end
    // flag 0 sweep
    monEnable = 0; waitCyc(2);
    for (int lk = 1; lk >= 0; lk--) begin
      lockDet = lk[0];
      for (int s = 0; s < 16; s++) begin
        muxSel = s[3:0]; waitCyc(1);
        check("R7/R8/R9 sweep clear", statusOut, expStatus(0, lk[0], s[3:0]));
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule